// File: doc/BRIEF.md
# Fully-Associative Translation Buffer with Use and Dirty Tracking

This block holds a small set of recently used page table entries and turns a virtual page number into a physical page number for load and store requests. Every entry can hold any virtual page, and a request is compared against all entries at once. A request that matches gets its physical page number on the following cycle. A request that does not match is answered with a miss, and the requester is expected to retry once a page table walker has supplied the entry through the refill port.

Each entry carries a valid flag, a use flag and a modified flag. A hit sets the use flag, and a store that hits also sets the modified flag. An external command wipes all use flags, so the flags that remain set show recent activity. The refill logic uses them to choose which entry to displace. Modified status lives only inside the buffer. When a modified entry is displaced, or when the whole buffer is invalidated, the virtual page number of each modified entry is presented on a writeback port so that the page table can be updated.

Top module: `tlb_assoc`

## Requirements
- R1: A request whose virtual page number matches any valid entry, at any index, is a hit; no two valid entries ever hold the same virtual page number.
- R2: Each request cycle produces, on the next cycle, exactly one of `rsp_hit` or `rsp_miss`; on a hit `rsp_ppn` carries the matching entry's physical page number.
- R3: On a miss, `rsp_ppn` is zero and no entry changes.
- R4: A hit sets that entry's use flag. `clr_use` clears every use flag, but a hit in the same cycle still leaves its own entry's flag set.
- R5: A store request (`req_store`=1) that hits sets that entry's modified flag.
- R6: A refill of a new page replaces the lowest-indexed invalid entry; if none is invalid, the lowest-indexed entry whose use flag is 0; otherwise entry 0. The victim is chosen from the flags held before the cycle.
- R7: A refilled entry becomes valid with its use flag at 1 and its modified flag at 0.
- R8: A refill whose virtual page number is already present rewrites that entry's physical page number in place, keeps its modified flag, and evicts nothing.
- R9: When a refill displaces a valid, modified entry, `wb_valid` pulses on the next cycle with that entry's virtual page number on `wb_vpn`; a clean victim gives no pulse.
- R10: A `flush` pulse raises `flush_busy` on the next cycle. While busy, one modified entry per cycle, lowest index first, appears on the writeback port; in the first busy cycle with none left, every entry is invalidated and `flush_busy` falls. While busy, requests answer miss and refills are ignored.
- R11: After reset every entry is invalid and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_store | input | 1 | Request is a store |
| req_vpn | input | VPN_W | Virtual page number to translate |
| refill_valid | input | 1 | Write a page table entry |
| refill_vpn | input | VPN_W | Virtual page number of the refill |
| refill_ppn | input | PPN_W | Physical page number of the refill |
| clr_use | input | 1 | Clear all use flags |
| flush | input | 1 | Drain modified entries, then invalidate all |
| rsp_hit | output | 1 | Previous request hit |
| rsp_miss | output | 1 | Previous request missed; retry after refill |
| rsp_ppn | output | PPN_W | Physical page number of the hit |
| wb_valid | output | 1 | A modified entry is being written back |
| wb_vpn | output | VPN_W | Virtual page number being written back |
| flush_busy | output | 1 | Flush in progress |

## Verification
Translation is tried with a directed sequence that fills every entry and then hits each one in turn, which separates a correct parallel compare from one that only sees some indices. Refills are then issued with all use flags set, after a clear with a simultaneous hit, and against a page already present; each leaves a different victim (entry 0, the first unused entry, or none), seen through later hits and misses and through whether a writeback appears. A flush with two modified entries shows drain order, the forced misses and dropped refills while busy, and the empty buffer afterwards. A long random phase over a narrow page range mixes all inputs so that same-cycle combinations reach the reference model.

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             refill_valid,
  input  logic [VPN_W-1:0] refill_vpn,
  input  logic [PPN_W-1:0] refill_ppn,
  input  logic             clr_use,
  input  logic             flush,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             wb_valid,
  output logic [VPN_W-1:0] wb_vpn,
  output logic             flush_busy
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [ENTRIES-1:0] ONE = {{(ENTRIES-1){1'b0}}, 1'b1};

  logic [ENTRIES-1:0] valid_q, use_q, mod_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic               busy_q;

  logic [ENTRIES-1:0] hit_vec, same_vec;
  logic [PPN_W-1:0]   hit_ppn;
  logic [IDX_W-1:0]   free_idx, old_idx, drain_idx, victim;
  logic               free_found, old_found, drain_found;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g]  = valid_q[g] && (vpn_q[g] == req_vpn);
      assign same_vec[g] = valid_q[g] && (vpn_q[g] == refill_vpn);
    end
  endgenerate

  always_comb begin
    hit_ppn     = '0;
    free_found  = 1'b0;
    free_idx    = '0;
    old_found   = 1'b0;
    old_idx     = '0;
    drain_found = 1'b0;
    drain_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_ppn = hit_ppn | ppn_q[i];
      if (!valid_q[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (valid_q[i] && !use_q[i]) begin
        old_found = 1'b1;
        old_idx   = IDX_W'(i);
      end
      if (valid_q[i] && mod_q[i]) begin
        drain_found = 1'b1;
        drain_idx   = IDX_W'(i);
      end
    end
  end

  assign victim = free_found ? free_idx : (old_found ? old_idx : '0);

  logic               lookup_ok, lookup_hit, do_fill, same_hit, drain_now, evict_wb;
  logic [ENTRIES-1:0] touch, store_set, fill_mask, new_mask, drain_mask, victim_mask;

  assign lookup_ok   = req_valid && !busy_q;
  assign lookup_hit  = lookup_ok && (|hit_vec);
  assign touch       = lookup_ok ? hit_vec : '0;
  assign store_set   = req_store ? touch : '0;
  assign do_fill     = refill_valid && !busy_q;
  assign same_hit    = |same_vec;
  assign victim_mask = ONE << victim;
  assign fill_mask   = !do_fill ? '0 : (same_hit ? same_vec : victim_mask);
  assign new_mask    = same_hit ? '0 : fill_mask;
  assign drain_now   = busy_q && drain_found;
  assign drain_mask  = drain_now ? (ONE << drain_idx) : '0;
  assign evict_wb    = do_fill && !same_hit && valid_q[victim] &&
                       (mod_q[victim] || store_set[victim]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= '0;
      use_q      <= '0;
      mod_q      <= '0;
      busy_q     <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_ppn    <= '0;
      wb_valid   <= 1'b0;
      wb_vpn     <= '0;
    end else begin
      use_q    <= (clr_use ? '0 : use_q) | touch | fill_mask;
      mod_q    <= (mod_q | store_set) & ~new_mask & ~drain_mask;
      valid_q  <= (busy_q && !drain_found) ? '0 : (valid_q | fill_mask);
      busy_q   <= busy_q ? drain_found : flush;
      rsp_hit  <= lookup_hit;
      rsp_miss <= req_valid && !lookup_hit;
      rsp_ppn  <= lookup_hit ? hit_ppn : '0;
      wb_valid <= drain_now || evict_wb;
      wb_vpn   <= drain_now ? vpn_q[drain_idx] : (evict_wb ? vpn_q[victim] : '0);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_mask[i]) begin
        vpn_q[i] <= refill_vpn;
        ppn_q[i] <= refill_ppn;
      end
    end
  end

  assign flush_busy = busy_q;

  // R1
  uniq_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(hit_vec));

  // R2
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit != rsp_miss));

  // R2
  answer_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit || rsp_miss) |-> $past(req_valid));

  // R4
  use_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_use && !req_valid && !refill_valid) |=> (use_q == '0));

  // R5
  store_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !busy_q && (|hit_vec) && !refill_valid) |=> (mod_q != '0));

  // R9
  wb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(busy_q || refill_valid));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (valid_q == '0 && mod_q == '0));

endmodule

// File: tb/tlb_assoc_bench.sv
`timescale 1ns/1ps
module tlb_assoc_bench;
  localparam int E  = 4;
  localparam int VW = 12;
  localparam int PW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, refill_valid = 0, clr_use = 0, flush = 0;
  logic [VW-1:0] req_vpn = '0, refill_vpn = '0;
  logic [PW-1:0] refill_ppn = '0;
  logic rsp_hit, rsp_miss, wb_valid, flush_busy;
  logic [PW-1:0] rsp_ppn;
  logic [VW-1:0] wb_vpn;

  always #2.5 clk = ~clk;

  tlb_assoc #(.ENTRIES(E), .VPN_W(VW), .PPN_W(PW)) u_tlb_assoc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_vpn(req_vpn), .refill_valid(refill_valid), .refill_vpn(refill_vpn),
    .refill_ppn(refill_ppn), .clr_use(clr_use), .flush(flush),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_ppn(rsp_ppn),
    .wb_valid(wb_valid), .wb_vpn(wb_vpn), .flush_busy(flush_busy));

  int checks = 0;
  int failures = 0;

  bit         m_v [E];
  bit         m_u [E];
  bit         m_d [E];
  int         m_vpn [E];
  int         m_ppn [E];
  bit         m_busy = 0;
  bit         e_hit = 0, e_miss = 0, e_wb = 0;
  int         e_ppn = 0, e_wbvpn = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    int h = -1, same = -1, vic = -1, drn = -1;
    bit vdirty;
    for (int i = E - 1; i >= 0; i--) begin
      if (m_v[i] && m_vpn[i] == int'(req_vpn)) h = i;
      if (m_v[i] && m_vpn[i] == int'(refill_vpn)) same = i;
      if (m_v[i] && m_d[i]) drn = i;
    end
    for (int i = E - 1; i >= 0; i--) if (m_v[i] && !m_u[i]) vic = i;
    for (int i = E - 1; i >= 0; i--) if (!m_v[i]) vic = i;
    if (vic < 0) vic = 0;
    e_hit = req_valid && !m_busy && h >= 0;
    e_miss = req_valid && !e_hit;
    e_ppn = e_hit ? m_ppn[h] : 0;
    e_wb = 0;
    e_wbvpn = 0;
    if (clr_use) for (int i = 0; i < E; i++) m_u[i] = 0;
    if (e_hit) begin
      m_u[h] = 1;
      if (req_store) m_d[h] = 1;
    end
    if (m_busy) begin
      if (drn >= 0) begin
        e_wb = 1;
        e_wbvpn = m_vpn[drn];
        m_d[drn] = 0;
      end else begin
        for (int i = 0; i < E; i++) m_v[i] = 0;
        m_busy = 0;
      end
    end else begin
      if (refill_valid) begin
        if (same >= 0) begin
          m_ppn[same] = int'(refill_ppn);
          m_u[same] = 1;
        end else begin
          vdirty = m_v[vic] && m_d[vic];
          if (vdirty) begin
            e_wb = 1;
            e_wbvpn = m_vpn[vic];
          end
          m_v[vic] = 1; m_u[vic] = 1; m_d[vic] = 0;
          m_vpn[vic] = int'(refill_vpn);
          m_ppn[vic] = int'(refill_ppn);
        end
      end
      if (flush) m_busy = 1;
    end
  endtask

  task automatic compare_model();
    chk("R2 rsp_hit vs model", int'(rsp_hit), int'(e_hit));
    chk("R3 rsp_miss vs model", int'(rsp_miss), int'(e_miss));
    chk("R2 rsp_ppn vs model", int'(rsp_ppn), e_ppn);
    chk("R9 wb_valid vs model", int'(wb_valid), int'(e_wb));
    chk("R9 wb_vpn vs model", int'(wb_vpn), e_wbvpn);
    chk("R10 flush_busy vs model", int'(flush_busy), int'(m_busy));
  endtask

  task automatic idle();
    req_valid = 0; req_store = 0; req_vpn = '0;
    refill_valid = 0; refill_vpn = '0; refill_ppn = '0;
    clr_use = 0; flush = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_model();
    idle();
  endtask

  task automatic req(int vpn, bit st);
    req_valid = 1; req_store = st; req_vpn = VW'(vpn);
    step();
  endtask

  task automatic fill(int vpn, int ppn);
    refill_valid = 1; refill_vpn = VW'(vpn); refill_ppn = PW'(ppn);
    step();
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < E; i++) begin
      m_v[i] = 0; m_u[i] = 0; m_d[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 rsp_hit after reset", int'(rsp_hit), 0);
    chk("R11 rsp_miss after reset", int'(rsp_miss), 0);
    chk("R11 wb_valid after reset", int'(wb_valid), 0);
    chk("R11 flush_busy after reset", int'(flush_busy), 0);
    rst_n = 1;

    req('h005, 0);
    chk("R3 empty buffer misses", int'(rsp_miss), 1);
    chk("R3 miss ppn is zero", int'(rsp_ppn), 0);

    fill('h010, 'h021); fill('h011, 'h022); fill('h012, 'h023); fill('h013, 'h024);
    req('h012, 0);
    chk("R1 hit on entry 2", int'(rsp_ppn), 'h023);
    req('h013, 0);
    chk("R1 hit on last entry", int'(rsp_ppn), 'h024);
    req('h010, 0);
    chk("R2 hit on entry 0", int'(rsp_hit), 1);
    req('h011, 1);
    chk("R5 store hit answers", int'(rsp_ppn), 'h022);

    fill('h014, 'h025);
    chk("R9 clean victim no writeback", int'(wb_valid), 0);
    req('h010, 0);
    chk("R6 all used evicts entry 0", int'(rsp_miss), 1);
    req('h014, 0);
    chk("R7 refilled entry hits", int'(rsp_ppn), 'h025);

    clr_use = 1; req('h014, 0);
    fill('h015, 'h026);
    chk("R9 dirty victim writeback", int'(wb_valid), 1);
    chk("R6 first unused victim vpn", int'(wb_vpn), 'h011);
    req('h014, 0);
    chk("R4 same-cycle hit keeps use", int'(rsp_hit), 1);
    req('h011, 0);
    chk("R6 victim gone", int'(rsp_miss), 1);

    req('h012, 1);
    fill('h012, 'h030);
    chk("R8 present refill no eviction", int'(wb_valid), 0);
    req('h012, 0);
    chk("R8 rewritten ppn", int'(rsp_ppn), 'h030);
    req('h015, 0);
    chk("R8 other entries kept", int'(rsp_ppn), 'h026);

    req('h014, 1);
    flush = 1; step();
    chk("R10 busy after flush", int'(flush_busy), 1);
    req_valid = 1; req_vpn = VW'('h015);
    refill_valid = 1; refill_vpn = VW'('h017); refill_ppn = PW'('h031);
    step();
    chk("R10 first drain entry 0", int'(wb_vpn), 'h014);
    chk("R10 request misses while busy", int'(rsp_miss), 1);
    step();
    chk("R10 second drain kept dirty", int'(wb_vpn), 'h012);
    step();
    chk("R10 busy falls", int'(flush_busy), 0);
    chk("R10 no writeback at end", int'(wb_valid), 0);
    req('h015, 0);
    chk("R10 invalidated", int'(rsp_miss), 1);
    req('h017, 0);
    chk("R10 refill ignored while busy", int'(rsp_miss), 1);

    for (int n = 0; n < 3000; n++) begin
      req_valid = ($urandom_range(0, 1) == 1);
      req_store = ($urandom_range(0, 2) == 0);
      req_vpn = VW'($urandom_range(0, 7));
      refill_valid = ($urandom_range(0, 2) == 0);
      refill_vpn = VW'($urandom_range(0, 7));
      refill_ppn = PW'($urandom_range(0, 1023));
      clr_use = ($urandom_range(0, 15) == 0);
      flush = ($urandom_range(0, 63) == 0);
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule